// File: doc/BRIEF.md
# Data Access Address Translator

This block turns the virtual address of a data load or store into a physical address, or into exactly one fault with a status-flag vector. The checks run in a fixed priority order. Alignment comes first. The next step depends on the access kind: an untranslated physical access, a fixed-window direct mapping reserved for kernel code (the "superpage"), or a table lookup. On the table path the block then checks for a miss, per-mode read and write permission, and the fault-on-read and fault-on-write bits. Last come a physical address range check and the rewriting of uncacheable addresses.

The translation buffer storage sits outside the block. The surrounding logic presents the lookup result for the request: hit, page number, per-mode enables and fault-on bits. It also supplies the privilege context: current mode, alternate mode, a privileged-code PC indicator and the alternate-mode request flag. A request is accepted on `reqValid`. The result appears on the outputs one clock later with `rspValid` and is held until the next request.

Top module: `dxl_translate`

## Requirements
- R1: A request with `reqValid` high produces `rspValid` high exactly one cycle later. `rspValid` is low in every other cycle. Reset clears every output to zero.
- R2: An access whose address ANDed with (`sizeBytes` − 1) is nonzero reports the alignment fault. This check outranks every other check. Its flag vector holds only the write bit, and that bit mirrors `isWrite`.
- R3: With `physMode` set, the physical address equals the virtual address and no translation or canonical check is done.
- R4: When `physMode` is clear and bits 63:47 of the address are not all equal, the block reports a page fault with the bad-address and access-violation flags set, plus the write flag on stores.
- R5: A canonical address whose bits 47:41 equal 0x7E uses the direct window. It is allowed only when `curMode` is kernel (0). In any other mode it raises an access-violation fault with the access-violation flag, plus the write flag on stores. The window keeps address bits 39:0. Bits 43:40 become all ones when address bit 40 is 1 and all zeros otherwise.
- R6: On the table path, a lookup miss raises a miss fault with the miss flag, plus the write flag on stores. The fault is the nested-miss type when `vpteReq` is set and the plain miss type otherwise.
- R7: On a hit, the physical address is `tbPpn` shifted left by 13 ORed with address bits 12:0.
- R8: The mode used for the permission checks is `curMode` when `palPc` is low. When `palPc` is high it is `altMode` if `altReq` is set, and kernel otherwise.
- R9: A store whose write enable for the effective mode is clear raises a page fault with the write and access-violation flags, plus the fault-on-write flag if `tbFonw` is set. A permitted store with `tbFonw` set raises a page fault with the write and fault-on-write flags.
- R10: A load whose read enable for the effective mode is clear raises an access-violation fault with the access-violation flag, plus the fault-on-read flag if `tbFonr` is set. A permitted load with `tbFonr` set raises a page fault with only the fault-on-read flag.
- R11: A resulting physical address with any bit above bit 43 set raises a machine-check fault with all flags clear.
- R12: A resulting address with bit 43 set is reported with `uncacheable` high and bits 42:35 cleared. If bits 42:35 are all ones, the address is in the internal-register window instead, and the block raises the unimplemented fault with all flags clear.
- R13: At most one fault is reported per request. Fault codes: none 0, alignment 1, page 2, access violation 3, miss 4, nested miss 5, machine check 6, unimplemented 7. Flag bits: write 0, bad address 1, access violation 2, miss 3, fault-on-read 4, fault-on-write 5. On a fault, `pa` is zero and `uncacheable` is low. Without a fault, the code is 0 and the flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| va | input | 64 | Virtual address |
| sizeBytes | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| isWrite | input | 1 | Store when high, load when low |
| physMode | input | 1 | Untranslated physical access |
| vpteReq | input | 1 | Access is a page-table-entry fetch |
| altReq | input | 1 | Use the alternate mode in privileged code |
| palPc | input | 1 | The PC is in privileged code |
| curMode | input | 2 | Current privilege mode (0 kernel) |
| altMode | input | 2 | Alternate privilege mode |
| tbHit | input | 1 | Lookup hit |
| tbPpn | input | 32 | Physical page number of the hit |
| tbReadEn | input | 4 | Read enable per mode |
| tbWriteEn | input | 4 | Write enable per mode |
| tbFonr | input | 1 | Fault-on-read bit |
| tbFonw | input | 1 | Fault-on-write bit |
| rspValid | output | 1 | Result valid |
| pa | output | 44 | Physical address |
| uncacheable | output | 1 | Address is uncacheable |
| faultValid | output | 1 | A fault was raised |
| faultType | output | 3 | Fault code |
| faultFlags | output | 6 | Status flags |

## Verification
The assertions take `sizeBytes` to be a power of two between one and eight. A non-power size has no defined alignment. They also take the lookup fields to be stable in the cycle `reqValid` is high. Every directed request keeps to legal sizes and drives all inputs a half cycle before the capturing edge. Some scenarios select a path on which a lookup field is meaningless, such as physical mode or the direct window. In those scenarios the bench still drives that field to a value that would fault on the table path.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_PAGE  = 3'd2,
    FLT_ACV   = 3'd3,
    FLT_MISS  = 3'd4,
    FLT_DMISS = 3'd5,
    FLT_MCHK  = 3'd6,
    FLT_UNIMP = 3'd7
  } dxl_fault_e;

  localparam int FLG_WR    = 0;
  localparam int FLG_BADVA = 1;
  localparam int FLG_ACV   = 2;
  localparam int FLG_MISS  = 3;
  localparam int FLG_FONR  = 4;
  localparam int FLG_FONW  = 5;
  localparam int FLG_N     = 6;

  // path choice, made before the address exists
  typedef struct packed {
    logic selPhys;
    logic selSuper;
  } dxl_path_t;

  // final shaping, made once the address is checked
  typedef struct packed {
    logic zeroPa;
    logic clearUnc;
  } dxl_fin_t;

endpackage

// File: rtl/dxl_datapath.sv
module dxl_datapath
  import dxl_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_SIGN    = 47,
  parameter int PA_W       = 44,
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic [VA_W-1:0]  va,
  input  logic [3:0]       sizeBytes,
  input  logic [PPN_W-1:0] ppn,
  input  dxl_path_t        pathStb,
  input  dxl_fin_t         finStb,
  output logic             misaligned,
  output logic             vaNonCanon,
  output logic             vaSuper,
  output logic             paRangeBad,
  output logic             paUnc,
  output logic             paIpr,
  output logic [PA_W-1:0]  paOut
);

  localparam int SUPER_LO   = VA_SIGN - 6;
  localparam int SP_EXT_BIT = PA_W - 4;
  localparam int UNC_BIT    = PA_W - 1;
  localparam int CLR_HI     = PA_W - 2;
  localparam int CLR_LO     = PA_W - 9;
  localparam logic [6:0] SUPER_TAG = 7'h7E;

  logic [VA_W-1:0]      superPa;
  logic [VA_W-1:0]      tablePa;
  logic [VA_W-1:0]      rawPa;
  logic [VA_W-VA_SIGN-1:0] upperBits;
  logic [PA_W-1:0]      uncMask;

  always_comb begin
    upperBits  = va[VA_W-1:VA_SIGN];
    vaNonCanon = !((&upperBits) || (~|upperBits));
    vaSuper    = (va[VA_SIGN:SUPER_LO] == SUPER_TAG);
    misaligned = |(va[3:0] & (sizeBytes - 4'd1));
  end

  always_comb begin
    superPa = '0;
    superPa[SP_EXT_BIT-1:0] = va[SP_EXT_BIT-1:0];
    if (va[SP_EXT_BIT]) superPa[PA_W-1:SP_EXT_BIT] = '1;
    tablePa = (VA_W'(ppn) << PAGE_SHIFT) | VA_W'(va[PAGE_SHIFT-1:0]);
    if (pathStb.selPhys)       rawPa = va;
    else if (pathStb.selSuper) rawPa = superPa;
    else                       rawPa = tablePa;
  end

  always_comb begin
    paRangeBad = |rawPa[VA_W-1:PA_W];
    paUnc      = rawPa[UNC_BIT];
    paIpr      = &rawPa[CLR_HI:CLR_LO];
    uncMask    = '0;
    uncMask[CLR_HI:CLR_LO] = '1;
    if (finStb.zeroPa)        paOut = '0;
    else if (finStb.clearUnc) paOut = rawPa[PA_W-1:0] & ~uncMask;
    else                      paOut = rawPa[PA_W-1:0];
  end

endmodule

// File: rtl/dxl_ctrl.sv
module dxl_ctrl
  import dxl_pkg::*;
#(
  parameter int MODES  = 4,
  parameter int MODE_W = $clog2(MODES)
) (
  input  logic              isWrite,
  input  logic              physMode,
  input  logic              vpteReq,
  input  logic              altReq,
  input  logic              palPc,
  input  logic [MODE_W-1:0] curMode,
  input  logic [MODE_W-1:0] altMode,
  input  logic              tbHit,
  input  logic [MODES-1:0]  tbReadEn,
  input  logic [MODES-1:0]  tbWriteEn,
  input  logic              tbFonr,
  input  logic              tbFonw,
  input  logic              misaligned,
  input  logic              vaNonCanon,
  input  logic              vaSuper,
  input  logic              paRangeBad,
  input  logic              paUnc,
  input  logic              paIpr,
  output dxl_path_t         pathStb,
  output dxl_fin_t          finStb,
  output logic              faultValid,
  output dxl_fault_e        faultType,
  output logic [FLG_N-1:0]  faultFlags
);

  localparam logic [MODE_W-1:0] KERNEL = '0;

  logic [MODE_W-1:0] effMode;
  logic              tablePath;

  always_comb begin
    if (palPc) effMode = altReq ? altMode : KERNEL;
    else       effMode = curMode;
    pathStb.selPhys  = physMode;
    pathStb.selSuper = !physMode && !vaNonCanon && vaSuper;
    tablePath        = !physMode && !vaNonCanon && !vaSuper;
  end

  always_comb begin
    faultType  = FLT_NONE;
    faultFlags = '0;
    if (misaligned) begin
      faultType = FLT_ALIGN;
      faultFlags[FLG_WR] = isWrite;
    end else if (!physMode && vaNonCanon) begin
      faultType = FLT_PAGE;
      faultFlags[FLG_WR]    = isWrite;
      faultFlags[FLG_BADVA] = 1'b1;
      faultFlags[FLG_ACV]   = 1'b1;
    end else if (pathStb.selSuper && curMode != KERNEL) begin
      faultType = FLT_ACV;
      faultFlags[FLG_WR]  = isWrite;
      faultFlags[FLG_ACV] = 1'b1;
    end else if (tablePath && !tbHit) begin
      faultType = vpteReq ? FLT_DMISS : FLT_MISS;
      faultFlags[FLG_WR]   = isWrite;
      faultFlags[FLG_MISS] = 1'b1;
    end else if (tablePath && isWrite && !tbWriteEn[effMode]) begin
      faultType = FLT_PAGE;
      faultFlags[FLG_WR]   = 1'b1;
      faultFlags[FLG_ACV]  = 1'b1;
      faultFlags[FLG_FONW] = tbFonw;
    end else if (tablePath && isWrite && tbFonw) begin
      faultType = FLT_PAGE;
      faultFlags[FLG_WR]   = 1'b1;
      faultFlags[FLG_FONW] = 1'b1;
    end else if (tablePath && !isWrite && !tbReadEn[effMode]) begin
      faultType = FLT_ACV;
      faultFlags[FLG_ACV]  = 1'b1;
      faultFlags[FLG_FONR] = tbFonr;
    end else if (tablePath && !isWrite && tbFonr) begin
      faultType = FLT_PAGE;
      faultFlags[FLG_FONR] = 1'b1;
    end else if (paRangeBad) begin
      faultType = FLT_MCHK;
    end else if (paUnc && paIpr) begin
      faultType = FLT_UNIMP;
    end
    faultValid      = (faultType != FLT_NONE);
    finStb.zeroPa   = faultValid;
    finStb.clearUnc = !faultValid && paUnc;
  end

endmodule

// File: rtl/dxl_translate.sv
module dxl_translate
  import dxl_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_SIGN    = 47,
  parameter int PA_W       = 44,
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int MODES      = 4,
  parameter int MODE_W     = $clog2(MODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   va,
  input  logic [3:0]        sizeBytes,
  input  logic              isWrite,
  input  logic              physMode,
  input  logic              vpteReq,
  input  logic              altReq,
  input  logic              palPc,
  input  logic [MODE_W-1:0] curMode,
  input  logic [MODE_W-1:0] altMode,
  input  logic              tbHit,
  input  logic [PPN_W-1:0]  tbPpn,
  input  logic [MODES-1:0]  tbReadEn,
  input  logic [MODES-1:0]  tbWriteEn,
  input  logic              tbFonr,
  input  logic              tbFonw,
  output logic              rspValid,
  output logic [PA_W-1:0]   pa,
  output logic              uncacheable,
  output logic              faultValid,
  output logic [2:0]        faultType,
  output logic [FLG_N-1:0]  faultFlags
);

  dxl_path_t        pathStb;
  dxl_fin_t         finStb;
  logic             misaligned, vaNonCanon, vaSuper;
  logic             paRangeBad, paUnc, paIpr;
  logic [PA_W-1:0]  paNext;
  logic             faultNext;
  dxl_fault_e       typeNext;
  logic [FLG_N-1:0] flagsNext;

  dxl_datapath #(
    .VA_W(VA_W), .VA_SIGN(VA_SIGN), .PA_W(PA_W),
    .PPN_W(PPN_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_dp (
    .va(va), .sizeBytes(sizeBytes), .ppn(tbPpn),
    .pathStb(pathStb), .finStb(finStb),
    .misaligned(misaligned), .vaNonCanon(vaNonCanon), .vaSuper(vaSuper),
    .paRangeBad(paRangeBad), .paUnc(paUnc), .paIpr(paIpr), .paOut(paNext)
  );

  dxl_ctrl #(.MODES(MODES), .MODE_W(MODE_W)) u_ctrl (
    .isWrite(isWrite), .physMode(physMode), .vpteReq(vpteReq),
    .altReq(altReq), .palPc(palPc), .curMode(curMode), .altMode(altMode),
    .tbHit(tbHit), .tbReadEn(tbReadEn), .tbWriteEn(tbWriteEn),
    .tbFonr(tbFonr), .tbFonw(tbFonw),
    .misaligned(misaligned), .vaNonCanon(vaNonCanon), .vaSuper(vaSuper),
    .paRangeBad(paRangeBad), .paUnc(paUnc), .paIpr(paIpr),
    .pathStb(pathStb), .finStb(finStb),
    .faultValid(faultNext), .faultType(typeNext), .faultFlags(flagsNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      pa          <= '0;
      uncacheable <= 1'b0;
      faultValid  <= 1'b0;
      faultType   <= 3'd0;
      faultFlags  <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        pa          <= paNext;
        uncacheable <= finStb.clearUnc;
        faultValid  <= faultNext;
        faultType   <= typeNext;
        faultFlags  <= flagsNext;
      end
    end
  end

endmodule

// File: rtl/dxl_translate_chk.sv
module dxl_translate_chk #(
  parameter int PA_W = 44
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            isWrite,
  input logic            rspValid,
  input logic [PA_W-1:0] pa,
  input logic            uncacheable,
  input logic            faultValid,
  input logic [2:0]      faultType,
  input logic [5:0]      faultFlags
);

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R2
  align_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && faultType == 3'd1) |->
      (faultFlags[5:1] == 5'd0 && faultFlags[0] == $past(isWrite)));

  // R6
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (faultType == 3'd4 || faultType == 3'd5)) |-> faultFlags[3]);

  // R12
  uncache_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    uncacheable |-> (pa[PA_W-1] && pa[PA_W-2:PA_W-9] == 8'd0 && !faultValid));

  // R11
  mchk_noflags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && faultType == 3'd6) |-> faultFlags == 6'd0);

  // R13
  one_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (faultValid == (faultType != 3'd0)));

  // R13
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && faultValid) |-> (pa == '0 && !uncacheable));

  // R13
  clean_noflags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !faultValid) |-> faultFlags == 6'd0);

endmodule

bind dxl_translate dxl_translate_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .isWrite(isWrite),
  .rspValid(rspValid), .pa(pa), .uncacheable(uncacheable),
  .faultValid(faultValid), .faultType(faultType), .faultFlags(faultFlags)
);

// File: tb/dxl_translate_tb.sv
module dxl_translate_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] va = '0;
  logic [3:0]  sizeBytes = 4'd1;
  logic        isWrite = 1'b0, physMode = 1'b0, vpteReq = 1'b0;
  logic        altReq = 1'b0, palPc = 1'b0;
  logic [1:0]  curMode = 2'd0, altMode = 2'd0;
  logic        tbHit = 1'b0;
  logic [31:0] tbPpn = '0;
  logic [3:0]  tbReadEn = '0, tbWriteEn = '0;
  logic        tbFonr = 1'b0, tbFonw = 1'b0;
  logic        rspValid, uncacheable, faultValid;
  logic [43:0] pa;
  logic [2:0]  faultType;
  logic [5:0]  faultFlags;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dxl_translate u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .va(va),
    .sizeBytes(sizeBytes), .isWrite(isWrite), .physMode(physMode),
    .vpteReq(vpteReq), .altReq(altReq), .palPc(palPc),
    .curMode(curMode), .altMode(altMode), .tbHit(tbHit), .tbPpn(tbPpn),
    .tbReadEn(tbReadEn), .tbWriteEn(tbWriteEn), .tbFonr(tbFonr),
    .tbFonw(tbFonw), .rspValid(rspValid), .pa(pa),
    .uncacheable(uncacheable), .faultValid(faultValid),
    .faultType(faultType), .faultFlags(faultFlags)
  );

  task automatic defaults();
    va = '0; sizeBytes = 4'd8; isWrite = 0; physMode = 0; vpteReq = 0;
    altReq = 0; palPc = 0; curMode = 0; altMode = 0;
    tbHit = 0; tbPpn = '0; tbReadEn = '0; tbWriteEn = '0;
    tbFonr = 0; tbFonw = 0;
  endtask

  // inputs set at a falling edge; result sampled at the next falling edge
  task automatic issue();
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expect_rsp(string req, logic [2:0] expType,
                            logic [5:0] expFlags, logic [43:0] expPa,
                            logic expUnc);
    nChecks++;
    if (rspValid !== 1'b1 || faultType !== expType || faultFlags !== expFlags ||
        pa !== expPa || uncacheable !== expUnc ||
        faultValid !== (expType != 3'd0)) begin
      nFails++;
      $display("FAIL %s: got v=%b type=%0d flags=%h pa=%h unc=%b, exp type=%0d flags=%h pa=%h unc=%b",
               req, rspValid, faultType, faultFlags, pa, uncacheable,
               expType, expFlags, expPa, expUnc);
    end
  endtask

  task automatic t_reset();
    nChecks++;
    if (rspValid !== 0 || faultValid !== 0 || pa !== '0 || uncacheable !== 0 ||
        faultType !== 0 || faultFlags !== 0) begin
      nFails++;
      $display("FAIL R1 reset: got v=%b f=%b pa=%h, exp all zero", rspValid, faultValid, pa);
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    nChecks++;
    if (rspValid !== 1'b0) begin
      nFails++;
      $display("FAIL R1 idle: got rspValid=%b exp 0", rspValid);
    end
  endtask

  task automatic t_align();
    defaults(); va = 64'h1002; sizeBytes = 4'd4; isWrite = 1;
    tbHit = 1; tbWriteEn = '1; issue();
    expect_rsp("R2 store misaligned", 3'd1, 6'h01, '0, 0);
    defaults(); va = 64'hFFFF_FFFF_0000_0004; sizeBytes = 4'd8; physMode = 1; issue();
    expect_rsp("R2 load misaligned outranks R11", 3'd1, 6'h00, '0, 0);
  endtask

  task automatic t_phys();
    defaults(); physMode = 1; va = 64'h0000_0123_4567_8AB8; issue();
    expect_rsp("R3 physical pass-through", 3'd0, 6'h00, 44'h123_4567_8AB8, 0);
    defaults(); physMode = 1; va = 64'h0004_0000_0000_0000; issue();
    expect_rsp("R11 physical out of range", 3'd6, 6'h00, '0, 0);
  endtask

  task automatic t_noncanon();
    defaults(); va = 64'h0001_0000_0000_0000; tbHit = 1; tbReadEn = '1; issue();
    expect_rsp("R4 load non-canonical", 3'd2, 6'h06, '0, 0);
    defaults(); va = 64'h0001_0000_0000_0000; isWrite = 1; issue();
    expect_rsp("R4 store non-canonical", 3'd2, 6'h07, '0, 0);
  endtask

  task automatic t_super();
    defaults(); va = 64'hFFFF_FC00_1234_5000; issue();
    expect_rsp("R5 window kernel", 3'd0, 6'h00, 44'h000_1234_5000, 0);
    defaults(); va = 64'hFFFF_FC00_1234_5000; curMode = 2'd3; palPc = 1; issue();
    expect_rsp("R5 window user mode", 3'd3, 6'h04, '0, 0);
    defaults(); va = 64'hFFFF_FD00_0000_2000; issue();
    expect_rsp("R5 R12 window bit40 uncacheable", 3'd0, 6'h00, 44'h800_0000_2000, 1);
    defaults(); va = 64'hFFFF_FDFF_8000_0000; issue();
    expect_rsp("R12 internal-register window", 3'd7, 6'h00, '0, 0);
  endtask

  task automatic t_miss();
    defaults(); va = 64'h2000; isWrite = 1; issue();
    expect_rsp("R6 store miss", 3'd4, 6'h09, '0, 0);
    defaults(); va = 64'h2000; vpteReq = 1; issue();
    expect_rsp("R6 nested miss", 3'd5, 6'h08, '0, 0);
  endtask

  task automatic t_hit();
    defaults(); va = 64'h0000_0000_0056_7ABC; sizeBytes = 4'd4; tbHit = 1;
    tbPpn = 32'h1234; tbReadEn = '1; issue();
    expect_rsp("R7 hit address", 3'd0, 6'h00, 44'h000_0246_9ABC, 0);
    defaults(); va = 64'h18; tbHit = 1; tbPpn = 32'h8000_0000; tbReadEn = '1; issue();
    expect_rsp("R11 hit out of range", 3'd6, 6'h00, '0, 0);
    defaults(); va = 64'h0; tbHit = 1; tbPpn = 32'h4000_0000; tbReadEn = '1; issue();
    expect_rsp("R12 hit uncacheable", 3'd0, 6'h00, 44'h800_0000_0000, 1);
  endtask

  task automatic t_store_perm();
    defaults(); va = 64'h4000; isWrite = 1; tbHit = 1; tbWriteEn = 4'b1110; tbFonw = 1; issue();
    expect_rsp("R9 store denied with fonw", 3'd2, 6'h25, '0, 0);
    defaults(); va = 64'h4000; isWrite = 1; tbHit = 1; tbWriteEn = '1; tbFonw = 1; issue();
    expect_rsp("R9 store fonw", 3'd2, 6'h21, '0, 0);
  endtask

  task automatic t_load_perm();
    defaults(); va = 64'h4000; curMode = 2'd3; tbHit = 1; tbReadEn = 4'b0111; issue();
    expect_rsp("R10 load denied", 3'd3, 6'h04, '0, 0);
    defaults(); va = 64'h4000; tbHit = 1; tbReadEn = '1; tbFonr = 1; issue();
    expect_rsp("R10 load fonr", 3'd2, 6'h10, '0, 0);
    defaults(); va = 64'h4000; tbHit = 1; tbReadEn = 4'b1110; tbFonr = 1; issue();
    expect_rsp("R10 load denied with fonr", 3'd3, 6'h14, '0, 0);
  endtask

  task automatic t_effmode();
    defaults(); va = 64'h6000; palPc = 1; curMode = 2'd3; tbHit = 1;
    tbPpn = 32'h3; tbReadEn = 4'b0001; issue();
    expect_rsp("R8 privileged code uses kernel", 3'd0, 6'h00, 44'h6000, 0);
    defaults(); va = 64'h6000; palPc = 1; altReq = 1; altMode = 2'd2; tbHit = 1;
    tbPpn = 32'h3; tbReadEn = 4'b0001; issue();
    expect_rsp("R8 alternate mode denied", 3'd3, 6'h04, '0, 0);
    defaults(); va = 64'h6000; palPc = 1; altReq = 1; altMode = 2'd2; tbHit = 1;
    tbPpn = 32'h3; tbReadEn = 4'b0100; issue();
    expect_rsp("R8 alternate mode allowed", 3'd0, 6'h00, 44'h6000, 0);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_align();
    t_phys();
    t_noncanon();
    t_super();
    t_miss();
    t_hit();
    t_store_perm();
    t_load_perm();
    t_effmode();
    t_idle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule